// File: doc/BRIEF.md
# Tagged Capability Memory Controller

This block is a small memory front end that keeps one validity tag bit for every 32-byte, aligned capability granule. The tag bits sit in their own array, next to an on-chip byte array. A capability access always moves a whole granule together with its tag. A plain data access moves 1, 2, 4 or 8 bytes, and every plain store clears the tag of the granule it lands in. A forged or partly overwritten capability can therefore never keep a set tag.

Atomic update of a capability uses a reserving tagged read followed by a conditional write. A single reservation register records the reserved granule. A conditional write takes effect only while that reservation still holds, and it reports success on a separate flag. Plain stores to one fixed device address do not reach the arrays: they appear on a side output instead. Every request is answered one cycle after it is presented. Address bits above the array size are ignored, so the array aliases across the address space.

Top module: `tagmem_ctrl`

## Requirements
- R1: A capability write (req_cap=1, req_wr=1, req_cond=0) stores req_tag and all 32 data bytes of the granule. A later capability read returns that tag on resp_tag and those bytes on resp_rdata, one cycle after the request, with resp_valid high.
- R2: Byte order: for an access of N bytes at address A, the byte at A+i holds register bits [(N-1-i)*8 +: 8]. N is 32 for capability accesses and 1<<req_size for plain ones (req_size 0..3 gives 1, 2, 4 or 8 bytes). Plain data uses the low N*8 bits, and a plain read returns zero above them.
- R3: A plain write of any size clears the tag of the granule at its address rounded down to a multiple of 32, and leaves every byte it does not cover unchanged.
- R4: A capability access whose address bits [4:0] are nonzero, or a plain access whose address is not a multiple of N, raises resp_err the next cycle. It changes no data, no tag and no reservation.
- R5: A reserving read (req_cap=1, req_wr=0, req_cond=1) returns the tag and data like a capability read, and sets the reservation on that granule.
- R6: A conditional write (req_wr=1, req_cond=1) succeeds and raises resp_sc_ok only when a valid reservation names its granule. On success a capability write stores both tag and data, and a plain write stores its data and clears the tag. On failure nothing changes.
- R7: The reservation is cleared by every conditional write, whether it succeeds or fails, and by every write that takes effect on the reserved granule.
- R8: A non-conditional plain write to address 0x7F000000 pulses mmio_valid the next cycle, with mmio_data set to the low 64 write bits and mmio_size set to req_size. It leaves data, tags and the reservation untouched.
- R9: Reset clears all tags and the reservation, and drives resp_valid, resp_err, resp_sc_ok and mmio_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cap | input | 1 | Capability (whole granule, tagged) access |
| req_cond | input | 1 | Reserving read or conditional write |
| req_addr | input | 64 | Byte address |
| req_size | input | 2 | Plain access size, 1 << req_size bytes |
| req_tag | input | 1 | Tag to store on a capability write |
| req_wdata | input | 256 | Write data, register view |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_rdata | output | 256 | Read data, register view |
| resp_tag | output | 1 | Tag of the granule read by a capability read |
| resp_sc_ok | output | 1 | Conditional write succeeded |
| resp_err | output | 1 | Misaligned request, ignored |
| mmio_valid | output | 1 | Plain store to the device address |
| mmio_data | output | 64 | Device store data |
| mmio_size | output | 2 | Device store size code |

## Verification
A wrong tag shows up on resp_tag at the next capability read of that granule, one cycle after that request. A bad byte lane shows up in the same cycle at a specific byte of resp_rdata. A stale or lost reservation stays hidden until the next conditional write, and then shows up one cycle later as a wrong resp_sc_ok. It also shows up as data or a tag that should, or should not, have changed on the following read. For this reason the tests always follow a conditional write with a readback, and they cover a misaligned access, a device store and a reset placed between a reserving read and its conditional write.

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl #(
  parameter int GRAN_BYTES = 32,
  parameter int NUM_GRAN = 16,
  parameter logic [63:0] MMIO_ADDR = 64'h7F00_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_wr,
  input  logic         req_cap,
  input  logic         req_cond,
  input  logic [63:0]  req_addr,
  input  logic [1:0]   req_size,
  input  logic         req_tag,
  input  logic [GRAN_BYTES*8-1:0] req_wdata,
  output logic         resp_valid,
  output logic [GRAN_BYTES*8-1:0] resp_rdata,
  output logic         resp_tag,
  output logic         resp_sc_ok,
  output logic         resp_err,
  output logic         mmio_valid,
  output logic [63:0]  mmio_data,
  output logic [1:0]   mmio_size
);
  localparam int OFF_W = $clog2(GRAN_BYTES);
  localparam int IDX_W = $clog2(NUM_GRAN);
  localparam int BA_W  = OFF_W + IDX_W;
  localparam int BYTES = GRAN_BYTES * NUM_GRAN;

  logic [7:0]          mem [BYTES];
  logic [NUM_GRAN-1:0] tags;
  logic                resv_valid;
  logic [IDX_W-1:0]    resv_gidx;

  logic [IDX_W-1:0] gidx;
  logic [BA_W-1:0]  baddr;
  logic [3:0]       nbytes;
  logic             bad, is_mmio, resv_hit, do_wr, ok_req;

  assign gidx     = req_addr[BA_W-1:OFF_W];
  assign baddr    = req_addr[BA_W-1:0];
  assign nbytes   = 4'd1 << req_size;
  assign bad      = req_cap ? (req_addr[OFF_W-1:0] != '0)
                            : ((req_addr[2:0] & (nbytes[2:0] - 3'd1)) != 3'd0);
  assign ok_req   = req_valid && !bad;
  assign is_mmio  = req_wr && !req_cap && !req_cond && (req_addr == MMIO_ADDR);
  assign resv_hit = resv_valid && (resv_gidx == gidx);
  assign do_wr    = ok_req && req_wr && !is_mmio && (!req_cond || resv_hit);

  always_ff @(posedge clk) begin
    if (do_wr) begin
      if (req_cap) begin
        for (int i = 0; i < GRAN_BYTES; i++)
          mem[{gidx, OFF_W'(i)}] <= req_wdata[(GRAN_BYTES-1-i)*8 +: 8];
      end else begin
        for (int i = 0; i < 8; i++)
          if (i < int'(nbytes))
            mem[baddr + BA_W'(i)] <= req_wdata[(int'(nbytes)-1-i)*8 +: 8];
      end
    end
    if (req_valid && !req_wr) begin
      resp_rdata <= '0;
      if (req_cap) begin
        for (int i = 0; i < GRAN_BYTES; i++)
          resp_rdata[(GRAN_BYTES-1-i)*8 +: 8] <= mem[{gidx, OFF_W'(i)}];
      end else begin
        for (int i = 0; i < 8; i++)
          if (i < int'(nbytes))
            resp_rdata[(int'(nbytes)-1-i)*8 +: 8] <= mem[baddr + BA_W'(i)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_tag   <= 1'b0;
      resp_sc_ok <= 1'b0;
      resp_err   <= 1'b0;
      mmio_valid <= 1'b0;
      mmio_data  <= '0;
      mmio_size  <= '0;
      tags       <= '0;
      resv_valid <= 1'b0;
      resv_gidx  <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && bad;
      resp_sc_ok <= ok_req && req_wr && req_cond && resv_hit;
      resp_tag   <= ok_req && !req_wr && req_cap && tags[gidx];
      mmio_valid <= ok_req && is_mmio;
      if (ok_req && is_mmio) begin
        mmio_data <= req_wdata[63:0];
        mmio_size <= req_size;
      end
      if (do_wr) tags[gidx] <= req_cap ? req_tag : 1'b0;
      if (ok_req) begin
        if (!req_wr && req_cap && req_cond) begin
          resv_valid <= 1'b1;
          resv_gidx  <= gidx;
        end else if (req_wr && !is_mmio && (req_cond || resv_hit)) begin
          resv_valid <= 1'b0;
        end
      end
    end
  end

  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (resp_valid == $past(req_valid)));

  assert_misaligned_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cap && req_addr[OFF_W-1:0] != '0) |=> resp_err);

  assert_err_no_tag_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && resp_err) |-> $stable(tags));

  assert_reserve_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_req && !req_wr && req_cap && req_cond) |=> resv_valid);

  assert_sc_only_on_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && resp_sc_ok) |-> $past(req_valid && req_wr && req_cond));

  assert_cond_clears_resv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_req && req_wr && req_cond) |=> !resv_valid);

  assert_mmio_keeps_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mmio_valid) |-> ($stable(tags) && !resp_sc_ok));
endmodule

// File: tb/tagmem_ctrl_test.sv
module tagmem_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, req_cap = 1'b0, req_cond = 1'b0, req_tag = 1'b0;
  logic [63:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic [255:0] req_wdata = '0;
  logic         resp_valid, resp_tag, resp_sc_ok, resp_err, mmio_valid;
  logic [255:0] resp_rdata;
  logic [63:0]  mmio_data;
  logic [1:0]   mmio_size;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  tagmem_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_cap(req_cap), .req_cond(req_cond), .req_addr(req_addr),
    .req_size(req_size), .req_tag(req_tag), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_tag(resp_tag),
    .resp_sc_ok(resp_sc_ok), .resp_err(resp_err), .mmio_valid(mmio_valid),
    .mmio_data(mmio_data), .mmio_size(mmio_size)
  );

  function automatic logic [255:0] pat(input logic [31:0] w);
    return {8{w}};
  endfunction

  task automatic check(input string rq, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic cap, input logic cond, input logic tag,
                       input logic [63:0] a, input logic [1:0] sz, input logic [255:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_cap = cap; req_cond = cond; req_tag = tag;
    req_addr = a; req_size = sz; req_wdata = d;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic cap_write(input logic [63:0] a, input logic tag, input logic [255:0] d);
    issue(1'b1, 1'b1, 1'b0, tag, a, 2'd0, d);
  endtask

  task automatic cap_read(input logic [63:0] a);
    issue(1'b0, 1'b1, 1'b0, 1'b0, a, 2'd0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R9", "resp_valid after reset", 256'(resp_valid), 256'd0);
    check("R9", "mmio_valid after reset", 256'(mmio_valid), 256'd0);
    check("R9", "resp_sc_ok after reset", 256'(resp_sc_ok), 256'd0);
    cap_read(64'h0);
    check("R9", "tag of granule 0 after reset", 256'(resp_tag), 256'd0);
  endtask

  task automatic t_cap_rw();
    cap_write(64'h20, 1'b1, pat(32'h0102_0304));
    cap_read(64'h20);
    check("R1", "resp_valid on read", 256'(resp_valid), 256'd1);
    check("R1", "tag read back", 256'(resp_tag), 256'd1);
    check("R1", "data read back", resp_rdata, pat(32'h0102_0304));
  endtask

  task automatic t_plain_clears();
    logic [255:0] e = pat(32'h0102_0304);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 64'h25, 2'd0, 256'hAB);
    cap_read(64'h20);
    e[215:208] = 8'hAB;
    check("R3", "tag cleared by byte write", 256'(resp_tag), 256'd0);
    check("R2", "byte 5 lands at register byte 26", resp_rdata, e);
    cap_write(64'h40, 1'b1, pat(32'h7777_7777));
    issue(1'b1, 1'b0, 1'b0, 1'b0, 64'h58, 2'd3, 256'h0102030405060708);
    cap_read(64'h40);
    check("R3", "dword at granule end clears rounded-down tag", 256'(resp_tag), 256'd0);
  endtask

  task automatic t_endian();
    issue(1'b1, 1'b0, 1'b0, 1'b0, 64'h40, 2'd2, 256'h1122_3344);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 64'h40, 2'd2, '0);
    check("R2", "word read", resp_rdata, 256'h1122_3344);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 64'h40, 2'd0, '0);
    check("R2", "byte at A is most significant", resp_rdata, 256'h11);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 64'h43, 2'd0, '0);
    check("R2", "byte at A+3 is least significant", resp_rdata, 256'h44);
  endtask

  task automatic t_misaligned();
    cap_write(64'h60, 1'b1, pat(32'hD1D1_D1D1));
    cap_write(64'h68, 1'b0, pat(32'hD2D2_D2D2));
    check("R4", "err on misaligned capability write", 256'(resp_err), 256'd1);
    cap_read(64'h60);
    check("R4", "tag untouched", 256'(resp_tag), 256'd1);
    check("R4", "data untouched", resp_rdata, pat(32'hD1D1_D1D1));
    issue(1'b1, 1'b0, 1'b0, 1'b0, 64'h42, 2'd2, 256'hFFFF_FFFF);
    check("R4", "err on misaligned word write", 256'(resp_err), 256'd1);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 64'h40, 2'd2, '0);
    check("R4", "word untouched", resp_rdata, 256'h1122_3344);
  endtask

  task automatic t_lr_sc();
    issue(1'b0, 1'b1, 1'b1, 1'b0, 64'h80, 2'd0, '0);
    check("R5", "reserving read tag", 256'(resp_tag), 256'd0);
    issue(1'b1, 1'b1, 1'b1, 1'b1, 64'h80, 2'd0, pat(32'hC0DE_0001));
    check("R6", "conditional write succeeds", 256'(resp_sc_ok), 256'd1);
    cap_read(64'h80);
    check("R6", "tag stored", 256'(resp_tag), 256'd1);
    check("R6", "data stored", resp_rdata, pat(32'hC0DE_0001));
    issue(1'b1, 1'b1, 1'b1, 1'b0, 64'h80, 2'd0, pat(32'hBAD0_BAD0));
    check("R7", "second conditional write fails", 256'(resp_sc_ok), 256'd0);
    cap_read(64'h80);
    check("R6", "failed write leaves data", resp_rdata, pat(32'hC0DE_0001));
    check("R6", "failed write leaves tag", 256'(resp_tag), 256'd1);
  endtask

  task automatic t_resv_kill();
    logic [255:0] e = pat(32'hA5A5_0000);
    cap_write(64'hA0, 1'b1, pat(32'hA5A5_0000));
    issue(1'b0, 1'b1, 1'b1, 1'b0, 64'hA0, 2'd0, '0);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 64'hA7, 2'd0, 256'h5A);
    issue(1'b1, 1'b1, 1'b1, 1'b1, 64'hA0, 2'd0, pat(32'h1111_1111));
    check("R7", "plain write to reserved granule kills reservation", 256'(resp_sc_ok), 256'd0);
    cap_read(64'hA0);
    e[199:192] = 8'h5A;
    check("R7", "tag after failed store", 256'(resp_tag), 256'd0);
    check("R7", "data after failed store", resp_rdata, e);
    issue(1'b0, 1'b1, 1'b1, 1'b0, 64'hC0, 2'd0, '0);
    issue(1'b1, 1'b1, 1'b1, 1'b1, 64'hE0, 2'd0, pat(32'h2222_2222));
    check("R6", "other granule does not match", 256'(resp_sc_ok), 256'd0);
    issue(1'b1, 1'b1, 1'b1, 1'b1, 64'hC0, 2'd0, pat(32'h3333_3333));
    check("R7", "any conditional write clears reservation", 256'(resp_sc_ok), 256'd0);
  endtask

  task automatic t_cond_plain();
    logic [255:0] e = pat(32'h8888_8888);
    cap_write(64'h100, 1'b1, pat(32'h8888_8888));
    issue(1'b0, 1'b1, 1'b1, 1'b0, 64'h100, 2'd0, '0);
    issue(1'b1, 1'b0, 1'b1, 1'b0, 64'h108, 2'd3, 256'h0102030405060708);
    check("R6", "conditional plain write succeeds", 256'(resp_sc_ok), 256'd1);
    cap_read(64'h100);
    e[191:128] = 64'h0102030405060708;
    check("R6", "conditional plain write clears tag", 256'(resp_tag), 256'd0);
    check("R6", "conditional plain write data", resp_rdata, e);
    cap_write(64'h120, 1'b1, pat(32'h9999_9999));
    issue(1'b1, 1'b0, 1'b1, 1'b0, 64'h120, 2'd3, 256'hFFFF);
    check("R6", "unreserved conditional plain write fails", 256'(resp_sc_ok), 256'd0);
    cap_read(64'h120);
    check("R6", "failed plain store keeps tag", 256'(resp_tag), 256'd1);
    check("R6", "failed plain store keeps data", resp_rdata, pat(32'h9999_9999));
  endtask

  task automatic t_mmio();
    cap_write(64'h0, 1'b1, pat(32'h4444_4444));
    issue(1'b0, 1'b1, 1'b1, 1'b0, 64'h0, 2'd0, '0);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 64'h7F00_0000, 2'd2, 256'hCAFE_F00D);
    check("R8", "mmio_valid pulse", 256'(mmio_valid), 256'd1);
    check("R8", "mmio_data", 256'(mmio_data), 256'hCAFE_F00D);
    check("R8", "mmio_size", 256'(mmio_size), 256'd2);
    issue(1'b1, 1'b1, 1'b1, 1'b1, 64'h0, 2'd0, pat(32'h5555_5555));
    check("R8", "mmio_valid drops", 256'(mmio_valid), 256'd0);
    check("R8", "reservation survives device store", 256'(resp_sc_ok), 256'd1);
    cap_read(64'h0);
    check("R8", "aliased granule tag", 256'(resp_tag), 256'd1);
    check("R8", "aliased granule data", resp_rdata, pat(32'h5555_5555));
  endtask

  task automatic t_reset_mid();
    issue(1'b0, 1'b1, 1'b1, 1'b0, 64'h60, 2'd0, '0);
    do_reset();
    issue(1'b1, 1'b1, 1'b1, 1'b1, 64'h60, 2'd0, pat(32'h6666_6666));
    check("R9", "reservation cleared by reset", 256'(resp_sc_ok), 256'd0);
    cap_read(64'h60);
    check("R9", "tag cleared by reset", 256'(resp_tag), 256'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap_rw();
    t_plain_clears();
    t_endian();
    t_misaligned();
    t_lr_sc();
    t_resv_kill();
    t_cond_plain();
    t_mmio();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule